// File: doc/BRIEF.md
# Uplink Gold Scrambling Code Generator

This block produces the complex long scrambling code for a single search. Two 25-stage linear feedback shift registers, X and Y, are combined into a Gold sequence. A code number written through the configuration port seeds the X register. The Y register always starts from all ones. Every chip-enable pulse moves the pair one chip ahead. The counter wraps after a whole frame of 38400 chips (15 slots of 2560 chips), and at that point both registers return to their seed state. An external frame-start strobe can force the same reload at any time.

Before a search period starts, a controller can fast-forward the generator by a whole number of correlation windows. This is the coarse offset. The window length is a parameter from 4 to 256 chips. During the advance the generator steps once per clock with no chip enable and raises a busy flag. Configuration writes, chip enables, frame strobes and new advance requests are all locked out until the advance is finished. The two output bits are the real and imaginary chips of the code at the current position.

The control is a three-state machine:
- **IDLE** is the state after reset, before any code is loaded. Only a configuration load leaves it (IDLE to RUN on load).
- **RUN** follows the frame. It stays in RUN on a load, a chip step or a frame strobe. It goes from RUN to ADVANCE on a non-zero advance request.
- **ADVANCE** steps the generator once per clock. It returns to RUN on the last step (ADVANCE to RUN on done).

Top module: `ulsc_gen`

## Requirements
- R1: After reset, `busy`, `chip_re` and `chip_im` are 0.
- R2: A `cfg_load` pulse accepted outside an advance sets X bits 23:0 to `cfg_code`, X bit 24 to 1 and all Y bits to 1, with the chip position at 0. The outputs show the new state in the cycle after the load.
- R3: In RUN, each cycle with `chip_en` high (and no `frame_start`) steps both registers once. X shifts right and takes the new bit 24 from X[0]^X[3]. Y shifts right and takes the new bit 24 from Y[0]^Y[1]^Y[2]^Y[3].
- R4: `chip_re` = X[0]^Y[0]. `chip_im` = X[4]^X[7]^X[18]^Y[4]^Y[6]^Y[17].
- R5: In RUN, `frame_start` reloads the seed state of the stored code and resets the chip position. It takes priority over `chip_en` in the same cycle.
- R6: When the register pair steps away from chip position 38399, it returns to the seed state, whether the step comes from `chip_en` or from an advance.
- R7: In RUN, an `adv_req` with `adv_windows` = N > 0 raises `busy` for exactly N*WIN_LEN cycles. The generator then stands where N*WIN_LEN chip steps would have put it.
- R8: While `busy` is high, `cfg_load`, `chip_en`, `frame_start` and `adv_req` have no effect on the code sequence.
- R9: An `adv_req` with `adv_windows` = 0, an `adv_req` in the same cycle as `cfg_load`, or an `adv_req` in IDLE is ignored: `busy` stays low.
- R10: In IDLE, `chip_en` and `frame_start` do not step or load the generator, and the outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Active-high synchronous reset |
| cfg_load | input | 1 | Load a new code number |
| cfg_code | input | 24 | Scrambling code number |
| adv_req | input | 1 | Start a coarse advance |
| adv_windows | input | ADV_W (10) | Advance length in windows |
| frame_start | input | 1 | Frame boundary strobe, reloads the seed state |
| chip_en | input | 1 | Step one chip |
| busy | output | 1 | Advance in progress |
| chip_re | output | 1 | Real code chip |
| chip_im | output | 1 | Imaginary code chip |

## Verification
The hardest situation to reach is an advance that crosses the frame boundary. Only then does the reload on the wrap interact with free-running stepping. The stimulus loads a code, requests a full frame's worth of windows, and expects to land exactly back on the seed sequence. It then advances one window short of a frame and lets `chip_en` carry the generator across the wrap, comparing each chip with a software model. Lock-out is reached by pulsing every control input in the middle of a long advance and then checking that the following chip sequence matches the model of the undisturbed advance.

// File: rtl/ulsc_pkg.sv
package ulsc_pkg;
    localparam int REG_W  = 25;
    localparam int CODE_W = 24;

    // feedback taps, bit k is stage k
    localparam logic [REG_W-1:0] X_TAPS = 25'h000_0009;
    localparam logic [REG_W-1:0] Y_TAPS = 25'h000_000F;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_ADV  = 2'd2
    } gen_state_e;

    function automatic logic imag_chip(input logic [REG_W-1:0] x, input logic [REG_W-1:0] y);
        return x[4] ^ x[7] ^ x[18] ^ y[4] ^ y[6] ^ y[17];
    endfunction
endpackage

// File: rtl/ulsc_lfsr.sv
module ulsc_lfsr #(
    parameter int                 WIDTH = 25,
    parameter logic [WIDTH-1:0]   TAPS  = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             step,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (step)
            q <= {^(q & TAPS), q[WIDTH-1:1]};
    end

    // R2
    lfsr_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(load_val));

    // R3
    lfsr_shift_chk: assert property (@(posedge clk) disable iff (rst)
        step && !load |=> q[WIDTH-2:0] == $past(q[WIDTH-1:1]));
endmodule

// File: rtl/ulsc_chip_ctr.sv
module ulsc_chip_ctr #(
    parameter int FRAME_LEN = 38400
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic wrap
);
    localparam int CNT_W = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    logic [CNT_W-1:0] cnt;

    assign wrap = step && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (step)
            cnt <= wrap ? '0 : cnt + 1'b1;
    end

    // R6
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        step && !clear && cnt == LAST |=> cnt == '0);

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/ulsc_gen.sv
module ulsc_gen
    import ulsc_pkg::*;
#(
    parameter int WIN_LEN   = 64,
    parameter int ADV_W     = 10,
    parameter int FRAME_LEN = 38400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [23:0]       cfg_code,
    input  logic              adv_req,
    input  logic [ADV_W-1:0]  adv_windows,
    input  logic              frame_start,
    input  logic              chip_en,
    output logic              busy,
    output logic              chip_re,
    output logic              chip_im
);
    localparam int LEFT_W = ADV_W + $clog2(WIN_LEN) + 1;

    gen_state_e        state, state_nx;
    logic [CODE_W-1:0] code_q;
    logic [LEFT_W-1:0] adv_left;
    logic [REG_W-1:0]  x_q, y_q, x_seed;
    logic cfg_accept, adv_start, adv_last, run_frame;
    logic step_run, step_any, wrap, reload;

    assign cfg_accept = cfg_load && (state != S_ADV);
    assign adv_start  = (state == S_RUN) && adv_req && !cfg_load && (adv_windows != '0);
    assign adv_last   = (state == S_ADV) && (adv_left == LEFT_W'(1));
    assign run_frame  = (state == S_RUN) && frame_start && !cfg_load;
    assign step_run   = (state == S_RUN) && chip_en && !frame_start && !cfg_load;
    assign step_any   = step_run || (state == S_ADV);
    assign reload     = cfg_accept || run_frame || wrap;
    assign x_seed     = {1'b1, cfg_accept ? cfg_code : code_q};

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (cfg_accept) state_nx = S_RUN;
            S_RUN:   if (adv_start)  state_nx = S_ADV;
            S_ADV:   if (adv_last)   state_nx = S_RUN;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = (state == S_ADV);
        chip_re = x_q[0] ^ y_q[0];
        chip_im = imag_chip(x_q, y_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q   <= '0;
            adv_left <= '0;
        end else begin
            if (cfg_accept)
                code_q <= cfg_code;
            if (adv_start)
                adv_left <= LEFT_W'(adv_windows) * LEFT_W'(WIN_LEN);
            else if (state == S_ADV)
                adv_left <= adv_left - 1'b1;
        end
    end

    ulsc_lfsr #(.WIDTH(REG_W), .TAPS(X_TAPS)) u_x (
        .clk(clk), .rst(rst), .load(reload), .load_val(x_seed),
        .step(step_any), .q(x_q));

    ulsc_lfsr #(.WIDTH(REG_W), .TAPS(Y_TAPS)) u_y (
        .clk(clk), .rst(rst), .load(reload), .load_val({REG_W{1'b1}}),
        .step(step_any), .q(y_q));

    ulsc_chip_ctr #(.FRAME_LEN(FRAME_LEN)) u_ctr (
        .clk(clk), .rst(rst), .clear(cfg_accept || run_frame),
        .step(step_any), .wrap(wrap));

    // R7
    adv_end_chk: assert property (@(posedge clk) disable iff (rst)
        adv_last |=> !busy);

    // R7
    adv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_ADV) && (adv_left != LEFT_W'(1)) |=> busy);

    // R8
    cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_ADV) && cfg_load |=> code_q == $past(code_q));

    // R9
    zero_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_RUN) && adv_req && (adv_windows == '0) |=> !busy);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) && !cfg_load |=> $stable(x_q) && $stable(y_q));
endmodule

// File: tb/ulsc_gen_tb.sv
module ulsc_gen_tb;
    localparam int WIN   = 64;
    localparam int FRAME = 38400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_load = 1'b0;
    logic [23:0] cfg_code = '0;
    logic adv_req = 1'b0;
    logic [9:0] adv_windows = '0;
    logic frame_start = 1'b0;
    logic chip_en = 1'b0;
    logic busy, chip_re, chip_im;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [24:0] mx, my;
    logic [23:0] mcode;
    int mcnt;

    always #4 clk = ~clk;

    ulsc_gen u_dut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_code(cfg_code),
        .adv_req(adv_req), .adv_windows(adv_windows), .frame_start(frame_start),
        .chip_en(chip_en), .busy(busy), .chip_re(chip_re), .chip_im(chip_im));

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            failures++;
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<190000", cycles);
            report();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    // software model
    task automatic m_reload;
        mx = {1'b1, mcode};
        my = '1;
        mcnt = 0;
    endtask

    task automatic m_step;
        if (mcnt == FRAME - 1) begin
            m_reload();
        end else begin
            mx = {mx[0] ^ mx[3], mx[24:1]};
            my = {my[0] ^ my[1] ^ my[2] ^ my[3], my[24:1]};
            mcnt++;
        end
    endtask

    function automatic int m_chips;
        return {30'd0, mx[0] ^ my[0],
                mx[4] ^ mx[7] ^ mx[18] ^ my[4] ^ my[6] ^ my[17]};
    endfunction

    function automatic int dut_chips;
        return {30'd0, chip_re, chip_im};
    endfunction

    task automatic do_load(input logic [23:0] code);
        cfg_load = 1'b1;
        cfg_code = code;
        tick();
        cfg_load = 1'b0;
        mcode = code;
        m_reload();
    endtask

    task automatic run_cmp(input string req, input int n);
        int bad = 0;
        int first_a = 0, first_e = 0;
        for (int i = 0; i < n; i++) begin
            chip_en = 1'b1;
            tick();
            m_step();
            if (dut_chips() != m_chips()) begin
                if (bad == 0) begin
                    first_a = dut_chips();
                    first_e = m_chips();
                end
                bad++;
            end
        end
        chip_en = 1'b0;
        check({req, " chip sequence mismatches"}, bad, 0);
        if (bad != 0)
            $display("  first mismatch actual=%0d expected=%0d", first_a, first_e);
    endtask

    task automatic do_adv(input string req, input int n);
        int cnt = 0;
        adv_req = 1'b1;
        adv_windows = 10'(n);
        tick();
        adv_req = 1'b0;
        while (busy && cnt < 60000) begin
            tick();
            cnt++;
        end
        check({req, " busy cycles"}, cnt, n * WIN);
        for (int i = 0; i < n * WIN; i++) m_step();
    endtask

    task automatic t_reset;
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        check("R1 busy after reset", busy, 0);
        check("R1 chips after reset", dut_chips(), 0);
    endtask

    task automatic t_idle;
        chip_en = 1'b1; frame_start = 1'b1; adv_req = 1'b1; adv_windows = 10'd3;
        tick(); tick(); tick();
        chip_en = 1'b0; frame_start = 1'b0; adv_req = 1'b0;
        check("R10 chips in idle", dut_chips(), 0);
        check("R9 busy after idle adv_req", busy, 0);
    endtask

    task automatic t_load_run(input logic [23:0] code, input int n);
        do_load(code);
        check("R2 chips after load", dut_chips(), m_chips());
        run_cmp("R3 R4 run", n);
    endtask

    task automatic t_frame_start;
        do_load(24'h5A5A5A);
        run_cmp("R3 pre-frame", 50);
        frame_start = 1'b1; chip_en = 1'b1;
        tick();
        frame_start = 1'b0; chip_en = 1'b0;
        m_reload();
        check("R5 chips after frame_start", dut_chips(), m_chips());
        run_cmp("R5 after frame_start", 40);
    endtask

    task automatic t_advance(input logic [23:0] code, input int n);
        do_load(code);
        do_adv("R7", n);
        check("R7 chips after advance", dut_chips(), m_chips());
        run_cmp("R7 after advance", 64);
    endtask

    task automatic t_wrap;
        do_load(24'hABCDEF);
        do_adv("R6 full frame", FRAME / WIN);
        check("R6 mcnt back to seed", mcnt, 0);
        check("R6 chips after full frame", dut_chips(), m_chips());
        run_cmp("R6 seq after full frame", 40);
        do_load(24'h13579B);
        do_adv("R6 near frame", FRAME / WIN - 1);
        run_cmp("R6 chip_en across wrap", 100);
    endtask

    task automatic t_lock;
        int cnt = 0;
        do_load(24'h00F00D);
        adv_req = 1'b1; adv_windows = 10'd4;
        tick();
        adv_req = 1'b0;
        cnt = 0;
        while (busy && cnt < 1000) begin
            if (cnt == 10) begin
                cfg_load = 1'b1; cfg_code = 24'h777777;
                chip_en = 1'b1; frame_start = 1'b1;
                adv_req = 1'b1; adv_windows = 10'd9;
            end else begin
                cfg_load = 1'b0; chip_en = 1'b0; frame_start = 1'b0; adv_req = 1'b0;
            end
            tick();
            cnt++;
        end
        cfg_load = 1'b0; chip_en = 1'b0; frame_start = 1'b0; adv_req = 1'b0;
        check("R8 busy cycles with noise", cnt, 4 * WIN);
        for (int i = 0; i < 4 * WIN; i++) m_step();
        run_cmp("R8 seq after locked advance", 64);
        // frame_start after lock must still reload the first code
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
        m_reload();
        run_cmp("R8 stored code unchanged", 30);
    endtask

    task automatic t_zero_adv;
        do_load(24'h2468AC);
        adv_req = 1'b1; adv_windows = 10'd0;
        tick();
        adv_req = 1'b0;
        check("R9 busy on zero advance", busy, 0);
        cfg_load = 1'b1; cfg_code = 24'h2468AC; adv_req = 1'b1; adv_windows = 10'd2;
        tick();
        cfg_load = 1'b0; adv_req = 1'b0;
        m_reload();
        check("R9 busy on adv with load", busy, 0);
        run_cmp("R9 seq unaffected", 20);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_load_run(24'h000000, 80);
        t_load_run(24'h000001, 80);
        t_load_run(24'hFFFFFF, 80);
        t_frame_start();
        t_advance(24'h123456, 1);
        t_advance(24'h00ABCD, 7);
        t_lock();
        t_zero_adv();
        t_wrap();
        report();
    end
endmodule